// File: doc/BRIEF.md
# Serial NOR Flash Modify-Operation Sequencer

This block runs whole modify operations on a serial NOR flash: sector erase, block erase, whole-chip erase, single-byte program and removal of block protection. A client places one request (operation code, 24-bit address, data byte) while the block is idle. The block then issues a chain of separate chip-select transactions to a lower-level SPI shift engine. Each transaction is described by a transmit length, a receive length and a packed byte array. The engine reports completion with a strobe and returns the single received byte.

Every modify command is preceded by its own write-enable transaction. A whole-chip erase first reads the status byte and clears any block-protect bits that are set. After the command, the block polls the busy bit at an interval chosen by the operation kind. A poll-count limit ends an operation whose busy bit never clears.

The controller is a single state machine with these states:

- IDLE: waits for a request.
- STAT: the initial status read.
- WE_SR: the write enable ahead of the status write.
- WRSR: the status write that clears protection.
- WE: the write enable ahead of the command.
- CMD: the erase or program command.
- WAIT: the pacing delay.
- POLL: a status read during polling.
- DONE: the one-cycle completion state.

The transitions are:

- IDLE→STAT: on a chip-erase or unprotect request.
- IDLE→WE: on a sector erase, block erase or byte program request.
- IDLE→DONE: on an unknown operation code.
- STAT→WE_SR: when the status read shows protection.
- STAT→WE: when a chip erase finds no protection.
- STAT→DONE: when an unprotect request finds no protection.
- WE_SR→WRSR.
- WRSR→WE: for a chip erase.
- WRSR→DONE: for an unprotect request.
- WE→CMD→WAIT.
- WAIT→POLL: when the interval expires.
- POLL→DONE: when the device is idle, or when the poll limit is reached.
- POLL→WAIT: when the device is still busy.
- DONE→IDLE.

Every transaction state leaves on the completion strobe.

Top module: `flash_op_sequencer`

## Requirements
- R1: `req_ready` is high exactly while the block is idle. A request is taken only when `req_valid` and `req_ready` are both high. A `req_valid` raised while the block is busy, including in the done cycle, starts nothing and leaves the running transaction sequence unchanged.
- R2: `done` is a one-cycle pulse, and `req_ready` is high in the following cycle. `error` is never high without `done`. `txn_start` is a one-cycle pulse for each transaction.
- R3: A separate write enable precedes every erase, program or status-write transaction. The write enable has transmit length 1, receive length 0 and byte 0x06.
- R4: Wire byte i sits at `txn_tx_bytes[8i+7:8i]`, and bytes beyond the transmit length are zero. Sector erase (code 0) sends 0x20 and block erase (code 1) sends 0xD8. Each has transmit length 4 and is followed by the address, most significant byte first.
- R5: Whole-chip erase (code 2) begins with a status read and sends the single byte 0xC7.
- R6: Byte program (code 3) sends 0x02, then the address most significant byte first, then the data byte, with transmit length 5.
- R7: After the command, the block polls the status with transactions of byte 0x05, transmit length 1 and receive length 1. It ends with `done` and no `error` on the first reply whose bit 0 is zero.
- R8: Each polling read starts exactly T+1 cycles after the completion strobe of the previous transaction. T is the tick parameter of the operation: T_CHIP, T_BLOCK, T_SECTOR or T_BYTE.
- R9: Protection removal applies to chip erase and to unprotect (code 4). If status bits 5..2 of the first read are nonzero, the block sends a write enable and then the two bytes 0x01 and (status with bits 5..2 cleared). Otherwise both transactions are skipped. Unprotect then finishes without polling.
- R10: After POLL_LIMIT busy replies, the block ends with `done` and `error`. When the reply at position POLL_LIMIT shows idle, the block ends without `error`.
- R11: Operation codes 5 to 7 end with `done` and `error` and issue no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code |
| req_addr | input | 24 | Flash byte address |
| req_data | input | 8 | Byte to program |
| req_ready | output | 1 | Idle, request can be taken |
| done | output | 1 | Operation finished pulse |
| error | output | 1 | Operation failed, valid with done |
| txn_start | output | 1 | Start one chip-select transaction |
| txn_tx_len | output | 3 | Bytes to transmit |
| txn_rx_len | output | 2 | Bytes to receive |
| txn_tx_bytes | output | 40 | Transmit bytes, wire byte i at bits 8i+7:8i |
| txn_done | input | 1 | Transaction complete strobe |
| txn_rx_byte | input | 8 | Received byte |

## Verification
Two coincidences get attention. The first is a new request that lands in the same cycle as the done pulse. The bench raises `req_valid` exactly in the cycle where it sees `done`, then confirms that no transaction follows and that the block stays idle. The second is a poll that reaches the limit on the same reply that reports idle. A device model that stays busy for POLL_LIMIT−1 reads and one that stays busy for POLL_LIMIT reads are compared: the first must end without `error`, the second with it. Both must issue exactly POLL_LIMIT status reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        OP_SECTOR = 3'd0,
        OP_BLOCK  = 3'd1,
        OP_CHIP   = 3'd2,
        OP_BYTE   = 3'd3,
        OP_UNPROT = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STAT,
        S_WE_SR,
        S_WRSR,
        S_WE,
        S_CMD,
        S_WAIT,
        S_POLL,
        S_DONE
    } state_e;

    localparam logic [7:0] CMD_WREN   = 8'h06;
    localparam logic [7:0] CMD_RDSR   = 8'h05;
    localparam logic [7:0] CMD_WRSR   = 8'h01;
    localparam logic [7:0] CMD_SECTOR = 8'h20;
    localparam logic [7:0] CMD_BLOCK  = 8'hD8;
    localparam logic [7:0] CMD_CHIP   = 8'hC7;
    localparam logic [7:0] CMD_PROG   = 8'h02;
    localparam logic [7:0] PROT_MASK  = 8'h3C;

endpackage

// File: rtl/seq_frame_build.sv
module seq_frame_build
    import flash_seq_pkg::*;
(
    input  state_e      st,
    input  op_e         op,
    input  logic [23:0] addr,
    input  logic [7:0]  data,
    input  logic [7:0]  stat,
    output logic [39:0] tx,
    output logic [2:0]  tx_len,
    output logic [1:0]  rx_len
);

    logic [23:0] addr_wire;

    // address bytes in wire order: most significant goes out first
    assign addr_wire = {addr[7:0], addr[15:8], addr[23:16]};

    always_comb begin
        tx     = '0;
        tx_len = 3'd0;
        rx_len = 2'd0;
        unique case (st)
            S_STAT, S_POLL: begin
                tx     = {32'h0, CMD_RDSR};
                tx_len = 3'd1;
                rx_len = 2'd1;
            end
            S_WE_SR, S_WE: begin
                tx     = {32'h0, CMD_WREN};
                tx_len = 3'd1;
            end
            S_WRSR: begin
                tx     = {24'h0, stat & ~PROT_MASK, CMD_WRSR};
                tx_len = 3'd2;
            end
            S_CMD: begin
                unique case (op)
                    OP_SECTOR: begin
                        tx     = {8'h00, addr_wire, CMD_SECTOR};
                        tx_len = 3'd4;
                    end
                    OP_BLOCK: begin
                        tx     = {8'h00, addr_wire, CMD_BLOCK};
                        tx_len = 3'd4;
                    end
                    OP_CHIP: begin
                        tx     = {32'h0, CMD_CHIP};
                        tx_len = 3'd1;
                    end
                    OP_BYTE: begin
                        tx     = {data, addr_wire, CMD_PROG};
                        tx_len = 3'd5;
                    end
                    default: begin
                        tx     = '0;
                        tx_len = 3'd0;
                    end
                endcase
            end
            default: begin
                tx     = '0;
                tx_len = 3'd0;
            end
        endcase
    end

endmodule

// File: rtl/seq_pace.sv
module seq_pace
    import flash_seq_pkg::*;
#(
    parameter int unsigned T_CHIP     = 100_000_000,
    parameter int unsigned T_BLOCK    = 10_000_000,
    parameter int unsigned T_SECTOR   = 1_000_000,
    parameter int unsigned T_BYTE     = 500,
    parameter int unsigned POLL_LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  op_e  op,
    input  logic waiting,
    input  logic restart,
    input  logic busy_seen,
    output logic interval_hit,
    output logic limit_hit
);

    localparam int unsigned PW = $clog2(POLL_LIMIT + 1);

    logic [31:0]   interval;
    logic [31:0]   tick_q;
    logic [PW-1:0] polls_q;

    always_comb begin
        unique case (op)
            OP_CHIP:   interval = T_CHIP;
            OP_BLOCK:  interval = T_BLOCK;
            OP_SECTOR: interval = T_SECTOR;
            default:   interval = T_BYTE;
        endcase
    end

    assign interval_hit = waiting && (tick_q == interval - 32'd1);
    assign limit_hit    = busy_seen && (polls_q == PW'(POLL_LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= '0;
            polls_q <= '0;
        end else begin
            tick_q <= waiting ? tick_q + 32'd1 : 32'd0;
            if (restart)
                polls_q <= '0;
            else if (busy_seen)
                polls_q <= polls_q + PW'(1);
        end
    end

    // R8
    tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> (tick_q < interval));

    // R10
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        polls_q <= PW'(POLL_LIMIT));

endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
    import flash_seq_pkg::*;
#(
    parameter int unsigned T_CHIP     = 100_000_000,
    parameter int unsigned T_BLOCK    = 10_000_000,
    parameter int unsigned T_SECTOR   = 1_000_000,
    parameter int unsigned T_BYTE     = 500,
    parameter int unsigned POLL_LIMIT = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [2:0]  req_op,
    input  logic [23:0] req_addr,
    input  logic [7:0]  req_data,
    output logic        req_ready,
    output logic        done,
    output logic        error,
    output logic        txn_start,
    output logic [2:0]  txn_tx_len,
    output logic [1:0]  txn_rx_len,
    output logic [39:0] txn_tx_bytes,
    input  logic        txn_done,
    input  logic [7:0]  txn_rx_byte
);

    state_e      state_q, state_n;
    op_e         op_q;
    logic [23:0] addr_q;
    logic [7:0]  data_q;
    logic [7:0]  stat_q;
    logic        err_q, err_n;
    logic        issued_q;
    logic        in_txn;
    logic        accept;
    logic        op_known;
    logic        protected_rx;
    logic        busy_seen;
    logic        interval_hit;
    logic        limit_hit;

    assign accept       = req_valid && (state_q == S_IDLE);
    assign op_known     = (req_op <= 3'd4);
    assign protected_rx = |(txn_rx_byte & PROT_MASK);
    assign busy_seen    = (state_q == S_POLL) && txn_done && txn_rx_byte[0];

    // next state
    always_comb begin
        state_n = state_q;
        err_n   = err_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    err_n = 1'b0;
                    if (!op_known) begin
                        err_n   = 1'b1;
                        state_n = S_DONE;
                    end else if (req_op == OP_CHIP || req_op == OP_UNPROT) begin
                        state_n = S_STAT;
                    end else begin
                        state_n = S_WE;
                    end
                end
            end
            S_STAT: begin
                if (txn_done) begin
                    if (protected_rx)
                        state_n = S_WE_SR;
                    else if (op_q == OP_CHIP)
                        state_n = S_WE;
                    else
                        state_n = S_DONE;
                end
            end
            S_WE_SR: if (txn_done) state_n = S_WRSR;
            S_WRSR: begin
                if (txn_done)
                    state_n = (op_q == OP_CHIP) ? S_WE : S_DONE;
            end
            S_WE:   if (txn_done) state_n = S_CMD;
            S_CMD:  if (txn_done) state_n = S_WAIT;
            S_WAIT: if (interval_hit) state_n = S_POLL;
            S_POLL: begin
                if (txn_done) begin
                    if (!txn_rx_byte[0]) begin
                        state_n = S_DONE;
                    end else if (limit_hit) begin
                        err_n   = 1'b1;
                        state_n = S_DONE;
                    end else begin
                        state_n = S_WAIT;
                    end
                end
            end
            S_DONE:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // state and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            op_q     <= OP_SECTOR;
            addr_q   <= '0;
            data_q   <= '0;
            stat_q   <= '0;
            err_q    <= 1'b0;
            issued_q <= 1'b0;
        end else begin
            state_q <= state_n;
            err_q   <= err_n;
            if (accept) begin
                op_q   <= op_known ? op_e'(req_op) : OP_SECTOR;
                addr_q <= req_addr;
                data_q <= req_data;
            end
            if (state_q == S_STAT && txn_done)
                stat_q <= txn_rx_byte;
            if (txn_done)
                issued_q <= 1'b0;
            else if (txn_start)
                issued_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        in_txn = 1'b0;
        unique case (state_q)
            S_STAT, S_WE_SR, S_WRSR, S_WE, S_CMD, S_POLL: in_txn = 1'b1;
            default: in_txn = 1'b0;
        endcase
        req_ready = (state_q == S_IDLE);
        done      = (state_q == S_DONE);
        error     = (state_q == S_DONE) && err_q;
        txn_start = in_txn && !issued_q;
    end

    seq_frame_build i_frame (
        .st     (state_q),
        .op     (op_q),
        .addr   (addr_q),
        .data   (data_q),
        .stat   (stat_q),
        .tx     (txn_tx_bytes),
        .tx_len (txn_tx_len),
        .rx_len (txn_rx_len)
    );

    seq_pace #(
        .T_CHIP     (T_CHIP),
        .T_BLOCK    (T_BLOCK),
        .T_SECTOR   (T_SECTOR),
        .T_BYTE     (T_BYTE),
        .POLL_LIMIT (POLL_LIMIT)
    ) i_pace (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op_q),
        .waiting      (state_q == S_WAIT),
        .restart      (accept),
        .busy_seen    (busy_seen),
        .interval_hit (interval_hit),
        .limit_hit    (limit_hit)
    );

    // guard: the previous transaction started was a write enable
    logic last_was_wren_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_was_wren_q <= 1'b0;
        else if (txn_start)
            last_was_wren_q <= (txn_tx_bytes[7:0] == CMD_WREN);
    end

    // R3
    wren_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && (txn_tx_bytes[7:0] == CMD_SECTOR || txn_tx_bytes[7:0] == CMD_BLOCK ||
                       txn_tx_bytes[7:0] == CMD_CHIP   || txn_tx_bytes[7:0] == CMD_PROG  ||
                       txn_tx_bytes[7:0] == CMD_WRSR)) |-> last_was_wren_q);

    // R9
    unprot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && txn_tx_bytes[7:0] == CMD_WRSR) |-> (txn_tx_bytes[13:10] == 4'b0000));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R2
    error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> !txn_start);

endmodule

// File: tb/test_flash_op_sequencer.sv
module test_flash_op_sequencer;

    localparam int TC = 9, TB = 7, TS = 5, TY = 2, LIM = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        req_ready, done, error, txn_start;
    logic [2:0]  txn_tx_len;
    logic [1:0]  txn_rx_len;
    logic [39:0] txn_tx_bytes;
    logic        txn_done = 1'b0;
    logic [7:0]  txn_rx_byte = '0;

    always #4 clk = ~clk;

    flash_op_sequencer #(
        .T_CHIP(TC), .T_BLOCK(TB), .T_SECTOR(TS), .T_BYTE(TY), .POLL_LIMIT(LIM)
    ) i_flash_op_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .done(done), .error(error), .txn_start(txn_start), .txn_tx_len(txn_tx_len),
        .txn_rx_len(txn_rx_len), .txn_tx_bytes(txn_tx_bytes), .txn_done(txn_done),
        .txn_rx_byte(txn_rx_byte)
    );

    int total = 0, bad = 0, cyc = 0;
    logic [44:0] exp_q[$];
    string       tag_q[$];
    int          resp_cnt = 0, last_done_cyc = 0, cur_t = 0, busy_left = 0, plan_busy = 0;
    bit          poll_phase = 0, got_done = 0, got_err = 0;
    logic [7:0]  dev_stat = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [44:0] mk(input int tl, input int rl, input logic [39:0] b);
        return {3'(tl), 2'(rl), b};
    endfunction

    task automatic push(input logic [44:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // one clock: device model, monitor and watchdog, all at the falling edge
    task automatic step();
        logic [44:0] got, e;
        string tg;
        @(negedge clk);
        cyc++;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog R2 actual=%0d expected=<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (resp_cnt > 0) begin
            resp_cnt--;
            if (resp_cnt == 0) begin
                txn_done = 1'b1;
                last_done_cyc = cyc;
            end
        end else begin
            txn_done = 1'b0;
        end
        check(done || !error, "R2 error without done", 64'(error), 64'(0));
        if (txn_start) begin
            got = {txn_tx_len, txn_rx_len, txn_tx_bytes};
            if (exp_q.size() == 0) begin
                check(0, "R1 unexpected transaction", 64'(got), 64'(0));
            end else begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(got == e, tg, 64'(got), 64'(e));
            end
            unique case (txn_tx_bytes[7:0])
                8'h05: begin
                    if (poll_phase) begin
                        check(cyc - last_done_cyc == cur_t + 1, "R8 poll spacing",
                              64'(cyc - last_done_cyc), 64'(cur_t + 1));
                        txn_rx_byte = dev_stat | 8'(busy_left > 0);
                        if (busy_left > 0) busy_left--;
                    end else begin
                        txn_rx_byte = dev_stat;
                    end
                end
                8'h01: dev_stat = txn_tx_bytes[15:8];
                8'h20, 8'hD8, 8'hC7, 8'h02: begin
                    poll_phase = 1;
                    busy_left  = plan_busy;
                end
                default: ;
            endcase
            resp_cnt = 2;
        end
        if (done) begin
            got_done   = 1;
            got_err    = error;
            poll_phase = 0;
        end
    endtask

    task automatic run_op(input int op, input logic [23:0] a, input logic [7:0] d,
                          input logic [7:0] istat, input int nbusy, input int intr_at,
                          input bit inj_done);
        bit exp_err;
        int k;
        logic [23:0] aw;
        aw = {a[7:0], a[15:8], a[23:16]};
        exp_q.delete();
        tag_q.delete();
        dev_stat  = istat;
        plan_busy = nbusy;
        cur_t     = (op == 2) ? TC : (op == 1) ? TB : (op == 0) ? TS : TY;
        exp_err   = (op > 4) || ((op <= 3) && (op != 2 || 1) && nbusy >= LIM && op != 4);
        if (op == 2 || op == 4) begin
            push(mk(1, 1, 40'h05), "R5 status read first");
            if ((istat & 8'h3C) != 0) begin
                push(mk(1, 0, 40'h06), "R3 write enable before status write");
                push(mk(2, 0, {24'h0, istat & 8'hC3, 8'h01}), "R9 status write");
            end
        end
        if (op <= 3) begin
            push(mk(1, 0, 40'h06), "R3 write enable before command");
            unique case (op)
                0: push(mk(4, 0, {8'h00, aw, 8'h20}), "R4 sector erase frame");
                1: push(mk(4, 0, {8'h00, aw, 8'hD8}), "R4 block erase frame");
                2: push(mk(1, 0, 40'hC7), "R5 chip erase frame");
                default: push(mk(5, 0, {d, aw, 8'h02}), "R6 byte program frame");
            endcase
            for (int i = 0; i < ((nbusy < LIM) ? nbusy + 1 : LIM); i++)
                push(mk(1, 1, 40'h05), "R7 poll read");
        end
        check(req_ready === 1'b1, "R1 ready before request", 64'(req_ready), 64'(1));
        got_done  = 0;
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_addr  = a;
        req_data  = d;
        step();
        req_valid = 1'b0;
        check(req_ready === 1'b0, "R1 busy after accept", 64'(req_ready), 64'(0));
        k = 0;
        while (!got_done) begin
            if (k == intr_at) begin
                req_valid = 1'b1;
                req_op    = 3'd2;
            end
            step();
            req_valid = 1'b0;
            k++;
        end
        check(got_err == exp_err, (op > 4) ? "R11 bad code error" : "R10 error flag",
              64'(got_err), 64'(exp_err));
        check(exp_q.size() == 0, "R7 all transactions issued", 64'(exp_q.size()), 64'(0));
        if (inj_done) begin
            req_valid = 1'b1;
            req_op    = 3'd0;
        end
        step();
        req_valid = 1'b0;
        check(req_ready === 1'b1 && !done, "R2 idle after done", 64'(req_ready), 64'(1));
        repeat (5) step();
        check(req_ready === 1'b1, "R1 no start from ignored request", 64'(req_ready), 64'(1));
    endtask

    initial begin
        repeat (2) step();
        check(req_ready === 1'b1 && done === 1'b0 && error === 1'b0 && txn_start === 1'b0,
              "R2 reset state", {60'h0, req_ready, done, error, txn_start}, 64'h8);
        rst_n = 1'b1;
        step();
        run_op(0, 24'h123456, 8'h00, 8'h00, 2, -1, 0);   // R4 sector erase, two busy polls
        run_op(1, 24'hABCDEF, 8'h00, 8'h00, 0, -1, 1);   // R4 block erase, request at done (R1)
        run_op(3, 24'h00FF10, 8'hA5, 8'h00, 1, 3, 0);    // R6 byte program, request mid-run (R1)
        run_op(2, 24'h000000, 8'h00, 8'h00, 1, -1, 0);   // R5 chip erase, no protection
        run_op(2, 24'h000000, 8'h00, 8'h9C, 1, -1, 0);   // R9 chip erase with protection
        run_op(4, 24'h000000, 8'h00, 8'h3C, 0, -1, 0);   // R9 unprotect, protected
        run_op(4, 24'h000000, 8'h00, 8'h42, 0, -1, 0);   // R9 unprotect, nothing set
        run_op(0, 24'h000100, 8'h00, 8'h00, LIM, -1, 0); // R10 stuck busy
        run_op(1, 24'h000200, 8'h00, 8'h00, LIM - 1, -1, 0); // R10 idle on last allowed poll
        run_op(6, 24'h000000, 8'h00, 8'h00, 0, -1, 0);   // R11 unknown code
        run_op(5, 24'h000000, 8'h00, 8'h00, 0, -1, 0);   // R11 unknown code
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule